// File: doc/BRIEF.md
# ADC Window Watchdog Controller

This block sits between a 10-bit analog-to-digital converter and a byte-wide register bus. It paces conversions by sending a start pulse to the converter. It then takes each returned sample and compares it against a programmable window. A sample outside the window latches a sticky out-of-range flag, so software does not have to poll and judge every value.

Every sample also latches an end-of-conversion flag. Software clears both flags. One registered interrupt line reports either flag when that flag's own enable bit is set. Conversions run either one at a time or back to back.

Top module: `adc_window_wdog`

## Requirements
- R1: After reset, every register reads 0x00, except the upper-threshold registers, which read 0xFF (offset 2) and 0x03 (offset 3). `irq_o` and `conv_start_o` are low.
- R2: The thresholds are split across two registers each. The upper threshold uses offset 2 for bits [9:2] and offset 3 for bits [1:0], held in data bits [1:0]. The lower threshold uses offsets 4 and 5 in the same way. Unused bits read 0.
- R3: The last accepted sample reads back as bits [9:2] at offset 6 and bits [1:0] at offset 7, held in data bits [1:0]. The value is rebuilt as (offset6 << 2) + offset7.
- R4: An accepted sample below the lower threshold, or above the upper threshold, sets the out-of-range flag. This flag is bit 6 of the status register at offset 0.
- R5: A sample equal to either threshold, or between them, does not set the out-of-range flag.
- R6: The out-of-range flag (status bit 6) and the end-of-conversion flag (status bit 7) stay set. Writing 0 to a flag's bit clears it. Writing 1 leaves it unchanged.
- R7: When a flag is set by hardware and cleared by software in the same cycle, the set wins.
- R8: Every accepted sample sets status bit 7 and updates the result registers in the same clock edge.
- R9: `irq_o` is registered, one cycle after the flags. It equals (bit7 AND bit5) OR (bit6 AND bit4) of the status register. Bit 5 enables the end-of-conversion interrupt and bit 4 enables the out-of-range interrupt.
- R10: Control register bit 0 (offset 1) is the run bit. With control bit 1 clear, setting the run bit gives exactly one start pulse, and the accepted result clears the run bit.
- R11: With control bits 0 and 1 both set, a new start pulse follows each accepted result. Clearing bit 0 stops further starts and abandons any outstanding conversion.
- R12: A result strobe that arrives with no outstanding conversion is ignored. The result registers and the flags stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data (combinational) |
| conv_start_o | output | 1 | One-cycle conversion request to the converter |
| res_valid_i | input | 1 | Converter result strobe |
| res_data_i | input | 10 | Converter sample |
| irq_o | output | 1 | Shared interrupt |

## Verification
A software write of 0 to a status flag can arrive on the same clock edge as a result strobe that sets that flag. The bench provokes this by raising the write strobe and the result strobe together, using an out-of-window sample. It then requires both flags to read back set. A paired in-window case checks that the out-of-range flag only clears when no new out-of-window sample arrives.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int unsigned BUS_W = 8;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_STAT   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
  localparam logic [ADDR_W-1:0] A_THI_H  = 3'd2;
  localparam logic [ADDR_W-1:0] A_THI_L  = 3'd3;
  localparam logic [ADDR_W-1:0] A_TLO_H  = 3'd4;
  localparam logic [ADDR_W-1:0] A_TLO_L  = 3'd5;
  localparam logic [ADDR_W-1:0] A_RES_H  = 3'd6;
  localparam logic [ADDR_W-1:0] A_RES_L  = 3'd7;

  localparam int unsigned B_EOC    = 7;
  localparam int unsigned B_AWD    = 6;
  localparam int unsigned B_EOC_IE = 5;
  localparam int unsigned B_AWD_IE = 4;
  localparam int unsigned B_RUN    = 0;
  localparam int unsigned B_CONT   = 1;

  localparam int unsigned N_FLAG = 2;
  typedef enum logic [0:0] {F_EOC = 1'b0, F_AWD = 1'b1} flag_e;
endpackage

// File: rtl/awd_flag.sv
module awd_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // hardware set dominates software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= 1'b0;
    else if (set_i)   q_o <= 1'b1;
    else if (clr_i)   q_o <= 1'b0;
  end
endmodule

// File: rtl/awd_window.sv
module awd_window #(
  parameter int unsigned RES_W = 10
) (
  input  logic [RES_W-1:0] sample_i,
  input  logic [RES_W-1:0] thr_hi_i,
  input  logic [RES_W-1:0] thr_lo_i,
  output logic             outside_o
);
  logic below, above;
  assign below     = sample_i < thr_lo_i;
  assign above     = sample_i > thr_hi_i;
  assign outside_o = below | above;
endmodule

// File: rtl/awd_seq.sv
module awd_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic cont_i,
  input  logic res_valid_i,
  output logic start_o,
  output logic busy_o,
  output logic accept_o,
  output logic run_clr_o
);
  logic busy_q, start_q;

  assign accept_o  = res_valid_i & busy_q & run_i;
  assign run_clr_o = accept_o & ~cont_i;
  assign busy_o    = busy_q;
  assign start_o   = start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= run_i & ~busy_q;
      if (!run_i)           busy_q <= 1'b0;   // abandon outstanding conversion
      else if (!busy_q)     busy_q <= 1'b1;
      else if (res_valid_i) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_window_wdog.sv
module adc_window_wdog
  import awd_pkg::*;
#(
  parameter int unsigned RES_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              conv_start_o,
  input  logic              res_valid_i,
  input  logic [RES_W-1:0]  res_data_i,
  output logic              irq_o
);
  localparam int unsigned LO_W = RES_W - BUS_W;
  localparam logic [RES_W-1:0] THR_MAX = '1;

  logic [RES_W-1:0] thr_hi, thr_lo, res_q;
  logic run, cont, eoc_ie, awd_ie;
  logic conv_busy, accept, run_clr, outside;
  logic [N_FLAG-1:0] flag_set, flag_clr, flag_q;
  logic eoc, awd, wr_stat, wr_ctrl;

  assign wr_stat = reg_we_i && reg_addr_i == A_STAT;
  assign wr_ctrl = reg_we_i && reg_addr_i == A_CTRL;

  awd_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .cont_i(cont),
    .res_valid_i(res_valid_i), .start_o(conv_start_o), .busy_o(conv_busy),
    .accept_o(accept), .run_clr_o(run_clr)
  );

  awd_window #(.RES_W(RES_W)) u_win (
    .sample_i(res_data_i), .thr_hi_i(thr_hi), .thr_lo_i(thr_lo), .outside_o(outside)
  );

  assign flag_set[F_EOC] = accept;
  assign flag_set[F_AWD] = accept & outside;
  assign flag_clr[F_EOC] = wr_stat & ~reg_wdata_i[B_EOC];
  assign flag_clr[F_AWD] = wr_stat & ~reg_wdata_i[B_AWD];

  for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
    awd_flag u_flag (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(flag_set[g]),
      .clr_i(flag_clr[g]), .q_o(flag_q[g])
    );
  end

  assign eoc = flag_q[F_EOC];
  assign awd = flag_q[F_AWD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoc_ie <= 1'b0;
      awd_ie <= 1'b0;
      run    <= 1'b0;
      cont   <= 1'b0;
      thr_hi <= THR_MAX;
      thr_lo <= '0;
    end else begin
      if (wr_stat) begin
        eoc_ie <= reg_wdata_i[B_EOC_IE];
        awd_ie <= reg_wdata_i[B_AWD_IE];
      end
      if (wr_ctrl) begin
        run  <= reg_wdata_i[B_RUN];
        cont <= reg_wdata_i[B_CONT];
      end else if (run_clr) begin
        run  <= 1'b0;
      end
      if (reg_we_i) begin
        case (reg_addr_i)
          A_THI_H: thr_hi[RES_W-1:LO_W] <= reg_wdata_i;
          A_THI_L: thr_hi[LO_W-1:0]     <= reg_wdata_i[LO_W-1:0];
          A_TLO_H: thr_lo[RES_W-1:LO_W] <= reg_wdata_i;
          A_TLO_L: thr_lo[LO_W-1:0]     <= reg_wdata_i[LO_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (accept) res_q <= res_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= (eoc & eoc_ie) | (awd & awd_ie);
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_STAT: begin
        reg_rdata_o[B_EOC]    = eoc;
        reg_rdata_o[B_AWD]    = awd;
        reg_rdata_o[B_EOC_IE] = eoc_ie;
        reg_rdata_o[B_AWD_IE] = awd_ie;
      end
      A_CTRL: begin
        reg_rdata_o[B_RUN]  = run;
        reg_rdata_o[B_CONT] = cont;
      end
      A_THI_H: reg_rdata_o = thr_hi[RES_W-1:LO_W];
      A_THI_L: reg_rdata_o[LO_W-1:0] = thr_hi[LO_W-1:0];
      A_TLO_H: reg_rdata_o = thr_lo[RES_W-1:LO_W];
      A_TLO_L: reg_rdata_o[LO_W-1:0] = thr_lo[LO_W-1:0];
      A_RES_H: reg_rdata_o = res_q[RES_W-1:LO_W];
      A_RES_L: reg_rdata_o[LO_W-1:0] = res_q[LO_W-1:0];
      default: ;
    endcase
  end
endmodule

// File: rtl/awd_chk.sv
module awd_chk #(
  parameter int unsigned RES_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [2:0]       reg_addr_i,
  input logic [7:0]       reg_wdata_i,
  input logic             res_valid_i,
  input logic [RES_W-1:0] res_data_i,
  input logic             conv_start_o,
  input logic             irq_o,
  input logic             accept,
  input logic             conv_busy,
  input logic             run,
  input logic             cont,
  input logic             eoc,
  input logic             awd,
  input logic             awd_ie,
  input logic [RES_W-1:0] thr_hi,
  input logic [RES_W-1:0] thr_lo,
  input logic [RES_W-1:0] res_q
);
  logic out_win, clr_awd, wr_ctrl;
  assign out_win = (res_data_i < thr_lo) || (res_data_i > thr_hi);
  assign clr_awd = reg_we_i && reg_addr_i == 3'd0 && !reg_wdata_i[6];
  assign wr_ctrl = reg_we_i && reg_addr_i == 3'd1;

  AST_EOC_ON_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> eoc); // R8
  AST_AWD_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && out_win |=> awd); // R4
  AST_AWD_INSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !out_win && !awd |=> !awd); // R5
  AST_AWD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awd && !clr_awd |=> awd); // R6
  AST_SET_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && out_win && clr_awd |=> awd); // R7
  AST_IRQ_AWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awd && awd_ie |=> irq_o); // R9
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o); // R10
  AST_SINGLE_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !cont && !wr_ctrl |=> !run); // R10
  AST_CONT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && cont && !wr_ctrl |=> run); // R11
  AST_IDLE_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && !conv_busy |=> $stable(res_q)); // R12
endmodule

bind adc_window_wdog awd_chk #(.RES_W(RES_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .res_valid_i(res_valid_i), .res_data_i(res_data_i),
  .conv_start_o(conv_start_o), .irq_o(irq_o), .accept(accept), .conv_busy(conv_busy),
  .run(run), .cont(cont), .eoc(eoc), .awd(awd), .awd_ie(awd_ie),
  .thr_hi(thr_hi), .thr_lo(thr_lo), .res_q(res_q)
);

// File: tb/sim_adc_window_wdog.sv
`timescale 1ns/1ps
module sim_adc_window_wdog;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic reg_we = 1'b0, res_valid = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [9:0] res_data = '0;
  logic conv_start, irq;
  int checks = 0, errors = 0, starts = 0, used = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  adc_window_wdog u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .conv_start_o(conv_start),
    .res_valid_i(res_valid), .res_data_i(res_data), .irq_o(irq)
  );

  always @(posedge clk) if (conv_start) starts <= starts + 1;

  // {sample, expected out-of-range flag} with window 300..800
  localparam logic [10:0] VEC [8] = '{
    {10'd299, 1'b1}, {10'd300, 1'b0}, {10'd800, 1'b0}, {10'd801, 1'b1},
    {10'd0,   1'b1}, {10'd1023,1'b1}, {10'd550, 1'b0}, {10'd512, 1'b0}
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_start();
    while (starts <= used) @(negedge clk);
    used++;
  endtask

  task automatic conv(input logic [9:0] v);
    wait_start();
    @(negedge clk); res_valid = 1'b1; res_data = v;
    @(negedge clk); res_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; repeat (2) @(negedge clk); rst_ni = 1'b1; used = starts;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int s0;
    do_reset();
    // R1 reset values
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      chk("R1 reg", v, a == 2 ? 8'hFF : a == 3 ? 8'h03 : 8'h00);
    end
    chk("R1 irq", irq, 0);
    chk("R1 start", conv_start, 0);

    // R2 threshold split: upper 800, lower 300
    wr(3'd2, 8'(800 >> 2)); wr(3'd3, 8'hFF);
    wr(3'd4, 8'(300 >> 2)); wr(3'd5, 8'(300 & 3));
    rd(3'd2, v); chk("R2 hi_h", v, 800 >> 2);
    rd(3'd3, v); chk("R2 hi_l", v, 3);
    rd(3'd4, v); chk("R2 lo_h", v, 300 >> 2);
    rd(3'd5, v); chk("R2 lo_l", v, 300 & 3);
    wr(3'd3, 8'(800 & 3));

    // R11 continuous run through the vector table
    wr(3'd1, 8'h03);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] h, l;
      wr(3'd0, 8'h00);
      conv(VEC[i][10:1]);
      rd(3'd0, v);
      chk(VEC[i][0] ? "R4 outside" : "R5 inside/equal", v[6], VEC[i][0]);
      chk("R8 eoc", v[7], 1);
      rd(3'd6, h); rd(3'd7, l);
      chk("R3 result", (int'(h) << 2) + int'(l), int'(VEC[i][10:1]));
    end

    // R6 writing 1 keeps, 0 clears
    wr(3'd0, 8'h00); conv(10'd5);
    wr(3'd0, 8'hC0); rd(3'd0, v); chk("R6 keep", v[7:6], 2'b11);
    wr(3'd0, 8'h80); rd(3'd0, v); chk("R6 clr awd", v[7:6], 2'b10);
    conv(10'd400); rd(3'd0, v); chk("R6 stays clear", v[6], 0);

    // R7 set and clear in same cycle
    wait_start();
    @(negedge clk); res_valid = 1'b1; res_data = 10'd900;
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h00;
    @(negedge clk); res_valid = 1'b0; reg_we = 1'b0;
    rd(3'd0, v); chk("R7 set wins", v[7:6], 2'b11);

    // R9 interrupt
    wr(3'd0, 8'h10); conv(10'd500);
    @(negedge clk); chk("R9 eoc only no irq", irq, 0);
    conv(10'd100);
    @(negedge clk); chk("R9 awd irq", irq, 1);
    wr(3'd0, 8'hA0); @(negedge clk); chk("R9 eoc irq", irq, 1);
    wr(3'd0, 8'h20); @(negedge clk); chk("R9 irq drop", irq, 0);

    // R11 stop continuous
    wr(3'd1, 8'h00);
    repeat (3) @(negedge clk);
    s0 = starts;
    repeat (10) @(negedge clk);
    chk("R11 stopped", starts, s0);

    // R10 single mode
    do_reset();
    s0 = starts; used = starts;
    wr(3'd1, 8'h01);
    repeat (10) @(negedge clk);
    chk("R10 one start", starts - s0, 1);
    conv(10'd77);
    rd(3'd1, v); chk("R10 run cleared", v[0], 0);
    repeat (10) @(negedge clk);
    chk("R10 no restart", starts - s0, 1);

    // R12 strobe while idle
    wr(3'd0, 8'h00);
    @(negedge clk); res_valid = 1'b1; res_data = 10'd999;
    @(negedge clk); res_valid = 1'b0;
    rd(3'd6, v); chk("R12 res hi", v, 77 >> 2);
    rd(3'd7, v); chk("R12 res lo", v, 77 & 3);
    rd(3'd0, v); chk("R12 flags", v[7:6], 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule